// File: doc/BRIEF.md
# Reciprocal Divide Operand Fixup

This block prepares the two single-precision operands of a divide that is later finished by reciprocal iteration. It inspects the numerator and the denominator together. When either one is a NaN, an infinity or a zero, it replaces both with fixed values, supplies a final override result and raises the invalid or divide-by-zero flag. For any other pair, it rescales both operands by exact powers of two so that the later iteration steps stay inside the normal exponent range. It also reports a signed exponent adjustment for those later steps.

Special operand pairs are resolved by a fixed priority. NaNs come first, then the indeterminate forms, then zero and infinity substitutions. The ordinary path picks one of five scale patterns from exponent windows. All outputs are registered, so results appear one cycle after the inputs are presented.

Top module: `rdiv_fixup`

## Requirements
- R1: Outputs are registered. The values presented with valid_i high appear on the outputs after the next rising clock edge, with valid_o high. When valid_i is low, valid_o drops and the data outputs hold their last values. Reset clears every output to zero.
- R2: When both operands are NaN, num_o, den_o and result_o are all 0xFFFFFFFF and special_o is 1. invalid_o is 1 exactly when at least one of the NaNs has bit 22 clear, which marks a signaling NaN.
- R3: When exactly one operand is NaN, the outputs are the same all-ones NaN and special_o is 1, regardless of a zero or an infinity in the other operand. invalid_o is 1 exactly when that NaN has bit 22 clear. divzero_o stays 0.
- R4: Infinity over infinity and zero over zero, with any signs, give the all-ones NaN on all three value outputs, with invalid_o and special_o set.
- R5: A zero denominator not covered by R2 to R4 sets num_o to an infinity whose sign (bit 31) is the XOR of the operand signs. It sets den_o to 1.0 (0x3F800000), result_o equal to num_o, and special_o to 1. divzero_o is 1 only if the numerator is finite and nonzero.
- R6: If no earlier case applies, an infinite denominator or a zero numerator sets num_o to a zero with the XOR sign. Failing that, an infinite numerator sets num_o to an infinity with the XOR sign. In both cases den_o is 0x3F800000, result_o equals num_o, special_o is 1, and no flag is raised.
- R7: For ordinary operands, let e be the exponent field (bits 30:23), with a zero field counted as 1. Let D = e_num - e_den + 127. If D <= 23, the numerator is multiplied by 2^64, the denominator by 2^-64, and adjust_o is -64 (8-bit two's complement 0xC0).
- R8: For ordinary operands with D > 230, the numerator is multiplied by 2^-32, the denominator by 2^32, and adjust_o is +64 (0x40).
- R9: For ordinary operands with 23 < D <= 230, the first matching rule applies. If e_num <= 25, both operands are multiplied by 2^64. Otherwise, if e_den <= 1, both are multiplied by 2^32. Otherwise, if e_den > 252, both are multiplied by 2^-32. Otherwise both pass unchanged. adjust_o is 0 in all of these cases.
- R10: Scaling is exact. Denormal inputs are normalized first, so the scaled output is a normal number that keeps every significant mantissa bit and the sign. For ordinary operands, special_o, invalid_o, divzero_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| num_i | input | 32 | Numerator, single precision |
| den_i | input | 32 | Denominator, single precision |
| valid_o | output | 1 | Registered outputs are fresh |
| num_o | output | 32 | Fixed-up or rescaled numerator |
| den_o | output | 32 | Fixed-up or rescaled denominator |
| result_o | output | 32 | Override result for special pairs, zero otherwise |
| adjust_o | output | 8 | Signed exponent adjustment for the later steps |
| special_o | output | 1 | Special operand pair detected |
| invalid_o | output | 1 | Invalid-operation flag |
| divzero_o | output | 1 | Divide-by-zero flag |

## Verification
The invalid and divide-by-zero conditions can arise from the same operand pair. A signaling NaN numerator over a zero denominator matches both the NaN rule and the zero-denominator rule in one cycle. The bench presents that pair and a quiet-NaN variant of it, and requires the NaN rule to win: an all-ones result on every value output, invalid set only for the signaling case, and divide-by-zero low. It likewise pairs a zero-denominator rule with an infinite numerator and expects only the infinity substitution, with no flag.

// File: rtl/fixup_pkg.sv
package fixup_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam int IEXP_W = EXP_W + 3;
  localparam int SH_W   = $clog2(MAN_W + 1);

  localparam int SCALE_BIG   = 64;
  localparam int SCALE_SMALL = 32;

  // exponent windows
  localparam int LOW_LIM  = MAN_W;
  localparam int HIGH_LIM = (EMAX - 1) - (MAN_W + 1);
  localparam int NUM_TINY = MAN_W + 2;
  localparam int DEN_TINY = 1;
  localparam int DEN_HUGE = EMAX - 3;

  localparam logic [FP_W-1:0] NAN_ALL = '1;
  localparam logic [FP_W-1:0] ONE_VAL = {1'b0, EXP_W'(BIAS), {MAN_W{1'b0}}};

  typedef struct packed {
    logic                     sign;
    logic                     is_nan;
    logic                     is_snan;
    logic                     is_inf;
    logic                     is_zero;
    logic [EXP_W-1:0]         eff_exp;
    logic signed [IEXP_W-1:0] norm_exp;
    logic [MAN_W:0]           norm_man;
  } opnd_t;

  typedef enum logic [2:0] {
    SC_NONE,
    SC_NUP_DDN,
    SC_NDN_DUP,
    SC_UP_BIG,
    SC_UP_SMALL,
    SC_DN_SMALL
  } scale_e;

  localparam logic signed [IEXP_W-1:0] D_BIG   = IEXP_W'(SCALE_BIG);
  localparam logic signed [IEXP_W-1:0] D_SMALL = IEXP_W'(SCALE_SMALL);

  function automatic logic signed [IEXP_W-1:0] delta_of(scale_e s, logic for_num);
    case (s)
      SC_NUP_DDN:  return for_num ? D_BIG : -D_BIG;
      SC_NDN_DUP:  return for_num ? -D_SMALL : D_SMALL;
      SC_UP_BIG:   return D_BIG;
      SC_UP_SMALL: return D_SMALL;
      SC_DN_SMALL: return -D_SMALL;
      default:     return '0;
    endcase
  endfunction

  function automatic logic [FP_W-1:0] inf_val(logic s);
    return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  endfunction
endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import fixup_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  output opnd_t           opnd_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic [SH_W-1:0]  lead;
  logic             found;

  assign exp_f  = val_i[FP_W-2 -: EXP_W];
  assign frac_f = val_i[MAN_W-1:0];

  always_comb begin
    lead  = '0;
    found = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!found && frac_f[i]) begin
        lead  = SH_W'(MAN_W - i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    opnd_o.sign    = val_i[FP_W-1];
    opnd_o.is_nan  = (exp_f == EXP_W'(EMAX)) && (frac_f != '0);
    opnd_o.is_snan = opnd_o.is_nan && !frac_f[MAN_W-1];
    opnd_o.is_inf  = (exp_f == EXP_W'(EMAX)) && (frac_f == '0);
    opnd_o.is_zero = (exp_f == '0) && (frac_f == '0);
    opnd_o.eff_exp = (exp_f == '0) ? EXP_W'(1) : exp_f;
    if (exp_f == '0) begin
      // denormal: bring leading one to the hidden position
      opnd_o.norm_man = {1'b0, frac_f} << lead;
      opnd_o.norm_exp = IEXP_W'(1) - $signed({{(IEXP_W-SH_W){1'b0}}, lead});
    end else begin
      opnd_o.norm_man = {1'b1, frac_f};
      opnd_o.norm_exp = $signed({{(IEXP_W-EXP_W){1'b0}}, exp_f});
    end
  end
endmodule

// File: rtl/fp_scale.sv
module fp_scale
  import fixup_pkg::*;
(
  input  logic                     chk_en_i,
  input  logic                     sign_i,
  input  logic signed [IEXP_W-1:0] exp_i,
  input  logic [MAN_W:0]           man_i,
  input  logic signed [IEXP_W-1:0] delta_i,
  output logic [FP_W-1:0]          val_o
);
  logic signed [IEXP_W-1:0] exp_sum;

  assign exp_sum = exp_i + delta_i;
  assign val_o   = {sign_i, exp_sum[EXP_W-1:0], man_i[MAN_W-1:0]};

  always_comb begin
    if (chk_en_i) begin
      // R10
      scale_range_chk: assert (exp_sum > 0 && exp_sum < IEXP_W'(EMAX) && man_i[MAN_W])
        else $error("scaled exponent left the normal range");
    end
  end
endmodule

// File: rtl/fixup_select.sv
module fixup_select
  import fixup_pkg::*;
#(
  parameter int ADJ_W = 8
) (
  input  opnd_t                   num_i,
  input  opnd_t                   den_i,
  output logic                    special_o,
  output logic                    invalid_o,
  output logic                    divzero_o,
  output logic [FP_W-1:0]         sp_num_o,
  output logic [FP_W-1:0]         sp_den_o,
  output logic [FP_W-1:0]         sp_res_o,
  output scale_e                  scale_o,
  output logic signed [ADJ_W-1:0] adjust_o
);
  localparam logic signed [IEXP_W-1:0] BIAS_S = IEXP_W'(BIAS);
  localparam logic signed [IEXP_W-1:0] LOW_S  = IEXP_W'(LOW_LIM);
  localparam logic signed [IEXP_W-1:0] HIGH_S = IEXP_W'(HIGH_LIM);
  localparam logic signed [ADJ_W-1:0]  ADJ_DN = -ADJ_W'(SCALE_BIG);
  localparam logic signed [ADJ_W-1:0]  ADJ_UP = ADJ_W'(SCALE_BIG);

  logic                     sgn;
  logic                     nan_case;
  logic signed [IEXP_W-1:0] diff;

  assign sgn  = num_i.sign ^ den_i.sign;
  assign diff = $signed({{(IEXP_W-EXP_W){1'b0}}, num_i.eff_exp})
              - $signed({{(IEXP_W-EXP_W){1'b0}}, den_i.eff_exp}) + BIAS_S;

  always_comb begin
    special_o = 1'b1;
    invalid_o = 1'b0;
    divzero_o = 1'b0;
    nan_case  = 1'b0;
    sp_num_o  = '0;
    scale_o   = SC_NONE;
    if (num_i.is_nan && den_i.is_nan) begin
      nan_case  = 1'b1;
      invalid_o = num_i.is_snan | den_i.is_snan;
    end else if (num_i.is_nan) begin
      nan_case  = 1'b1;
      invalid_o = num_i.is_snan;
    end else if (den_i.is_nan) begin
      nan_case  = 1'b1;
      invalid_o = den_i.is_snan;
    end else if ((num_i.is_inf && den_i.is_inf) || (num_i.is_zero && den_i.is_zero)) begin
      nan_case  = 1'b1;
      invalid_o = 1'b1;
    end else if (den_i.is_zero) begin
      sp_num_o  = inf_val(sgn);
      divzero_o = !num_i.is_inf;
    end else if (den_i.is_inf || num_i.is_zero) begin
      sp_num_o  = {sgn, {(FP_W-1){1'b0}}};
    end else if (num_i.is_inf) begin
      sp_num_o  = inf_val(sgn);
    end else begin
      special_o = 1'b0;
      if (diff <= LOW_S)                                scale_o = SC_NUP_DDN;
      else if (diff > HIGH_S)                           scale_o = SC_NDN_DUP;
      else if (num_i.eff_exp <= EXP_W'(NUM_TINY))       scale_o = SC_UP_BIG;
      else if (den_i.eff_exp <= EXP_W'(DEN_TINY))       scale_o = SC_UP_SMALL;
      else if (den_i.eff_exp > EXP_W'(DEN_HUGE))        scale_o = SC_DN_SMALL;
    end
    if (nan_case) begin
      sp_num_o = NAN_ALL;
      sp_den_o = NAN_ALL;
      sp_res_o = NAN_ALL;
    end else begin
      sp_den_o = ONE_VAL;
      sp_res_o = special_o ? sp_num_o : '0;
    end
    case (scale_o)
      SC_NUP_DDN: adjust_o = ADJ_DN;
      SC_NDN_DUP: adjust_o = ADJ_UP;
      default:    adjust_o = '0;
    endcase
  end
endmodule

// File: rtl/rdiv_fixup.sv
module rdiv_fixup
  import fixup_pkg::*;
#(
  parameter int ADJ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [FP_W-1:0]  num_i,
  input  logic [FP_W-1:0]  den_i,
  output logic             valid_o,
  output logic [FP_W-1:0]  num_o,
  output logic [FP_W-1:0]  den_o,
  output logic [FP_W-1:0]  result_o,
  output logic [ADJ_W-1:0] adjust_o,
  output logic             special_o,
  output logic             invalid_o,
  output logic             divzero_o
);
  localparam int N_OPS = 2;

  logic [FP_W-1:0]         raw   [N_OPS];
  opnd_t                   opnd  [N_OPS];
  logic [FP_W-1:0]         scaled[N_OPS];

  logic                    sp_d, inv_d, dbz_d;
  logic [FP_W-1:0]         sp_num, sp_den, sp_res;
  scale_e                  scale;
  logic signed [ADJ_W-1:0] adj_d;

  assign raw[0] = num_i;
  assign raw[1] = den_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fp_classify u_cls (
      .val_i  (raw[g]),
      .opnd_o (opnd[g])
    );
    fp_scale u_scl (
      .chk_en_i (valid_i && !sp_d),
      .sign_i   (opnd[g].sign),
      .exp_i    (opnd[g].norm_exp),
      .man_i    (opnd[g].norm_man),
      .delta_i  (delta_of(scale, g == 0)),
      .val_o    (scaled[g])
    );
  end

  fixup_select #(.ADJ_W(ADJ_W)) u_sel (
    .num_i     (opnd[0]),
    .den_i     (opnd[1]),
    .special_o (sp_d),
    .invalid_o (inv_d),
    .divzero_o (dbz_d),
    .sp_num_o  (sp_num),
    .sp_den_o  (sp_den),
    .sp_res_o  (sp_res),
    .scale_o   (scale),
    .adjust_o  (adj_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      num_o     <= '0;
      den_o     <= '0;
      result_o  <= '0;
      adjust_o  <= '0;
      special_o <= 1'b0;
      invalid_o <= 1'b0;
      divzero_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        num_o     <= sp_d ? sp_num : scaled[0];
        den_o     <= sp_d ? sp_den : scaled[1];
        result_o  <= sp_res;
        adjust_o  <= adj_d;
        special_o <= sp_d;
        invalid_o <= inv_d;
        divzero_o <= dbz_d;
      end
    end
  end

  // R5
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(invalid_o && divzero_o));

  // R4
  invalid_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (special_o && num_o == NAN_ALL && den_o == NAN_ALL && result_o == NAN_ALL));

  // R5
  dbz_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    divzero_o |-> (special_o && num_o[FP_W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}
                   && result_o == num_o));

  // R9
  special_noadj_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    special_o |-> (adjust_o == '0));

  // R10
  ordinary_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !special_o) |-> (num_o[FP_W-2 -: EXP_W] != '0 && num_o[FP_W-2 -: EXP_W] != '1
                                 && den_o[FP_W-2 -: EXP_W] != '0 && result_o == '0));

  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !valid_i) |=> $stable(num_o) && $stable(den_o));
endmodule

// File: tb/tb_rdiv_fixup.sv
`timescale 1ns/1ps
module tb_rdiv_fixup;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] num_i = '0;
  logic [31:0] den_i = '0;
  logic        valid_o;
  logic [31:0] num_o, den_o, result_o;
  logic [7:0]  adjust_o;
  logic        special_o, invalid_o, divzero_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] NAN = 32'hFFFF_FFFF;
  localparam logic [31:0] ONE = 32'h3F80_0000;

  always #5 clk_i = ~clk_i;

  rdiv_fixup dut (
    .clk_i, .rst_ni, .valid_i, .num_i, .den_i, .valid_o, .num_o, .den_o,
    .result_o, .adjust_o, .special_o, .invalid_o, .divzero_o
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] n, logic [31:0] d);
    @(negedge clk_i);
    valid_i = 1'b1;
    num_i   = n;
    den_i   = d;
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_all(string req, logic [31:0] en, logic [31:0] ed, logic [31:0] er,
                            logic [7:0] ea, logic es, logic ei, logic ez);
    chk(req, "valid_o", 32'(valid_o), 32'd1);
    chk(req, "num_o", num_o, en);
    chk(req, "den_o", den_o, ed);
    chk(req, "result_o", result_o, er);
    chk(req, "adjust_o", 32'(adjust_o), 32'(ea));
    chk(req, "special_o", 32'(special_o), 32'(es));
    chk(req, "invalid_o", 32'(invalid_o), 32'(ei));
    chk(req, "divzero_o", 32'(divzero_o), 32'(ez));
  endtask

  task automatic t_reset_hold;
    chk("R1", "reset valid_o", 32'(valid_o), 32'd0);
    chk("R1", "reset num_o", num_o, 32'd0);
    chk("R1", "reset result_o", result_o, 32'd0);
    apply(32'h3F80_0000, 32'h4000_0000);
    expect_all("R1", 32'h3F80_0000, 32'h4000_0000, 32'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    valid_i = 1'b0;
    num_i   = 32'h7F80_0001;
    den_i   = 32'h0;
    @(posedge clk_i);
    #1;
    chk("R1", "idle valid_o", 32'(valid_o), 32'd0);
    chk("R1", "idle hold num_o", num_o, 32'h3F80_0000);
    chk("R1", "idle hold invalid_o", 32'(invalid_o), 32'd0);
  endtask

  task automatic t_nan_pair;
    apply(32'h7FC0_0000, 32'hFFC0_0001);
    expect_all("R2 quiet pair", NAN, NAN, NAN, 8'h00, 1'b1, 1'b0, 1'b0);
    apply(32'h7FC0_0000, 32'h7F80_0001);
    expect_all("R2 signaling den", NAN, NAN, NAN, 8'h00, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_single_nan;
    apply(32'h3F80_0000, 32'h7FC0_0000);
    expect_all("R3 quiet den", NAN, NAN, NAN, 8'h00, 1'b1, 1'b0, 1'b0);
    apply(32'hFF80_0001, 32'h4000_0000);
    expect_all("R3 signaling num", NAN, NAN, NAN, 8'h00, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_collision;
    // NaN rule must win over zero-denominator rule
    apply(32'h7F80_0001, 32'h0000_0000);
    expect_all("R3 snan over zero", NAN, NAN, NAN, 8'h00, 1'b1, 1'b1, 1'b0);
    apply(32'h7FC0_0000, 32'h8000_0000);
    expect_all("R3 qnan over zero", NAN, NAN, NAN, 8'h00, 1'b1, 1'b0, 1'b0);
    apply(32'h7F80_0000, 32'h8000_0000);
    expect_all("R5 inf over zero", 32'hFF80_0000, ONE, 32'hFF80_0000, 8'h00, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_indeterminate;
    apply(32'h7F80_0000, 32'hFF80_0000);
    expect_all("R4 inf/inf", NAN, NAN, NAN, 8'h00, 1'b1, 1'b1, 1'b0);
    apply(32'h8000_0000, 32'h0000_0000);
    expect_all("R4 0/0", NAN, NAN, NAN, 8'h00, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_zero_den;
    apply(32'hC000_0000, 32'h0000_0000);
    expect_all("R5 finite/0", 32'hFF80_0000, ONE, 32'hFF80_0000, 8'h00, 1'b1, 1'b0, 1'b1);
    apply(32'h0000_0001, 32'h8000_0000);
    expect_all("R5 denormal/-0", 32'hFF80_0000, ONE, 32'hFF80_0000, 8'h00, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_zero_inf;
    apply(32'h3F80_0000, 32'hFF80_0000);
    expect_all("R6 x/inf", 32'h8000_0000, ONE, 32'h8000_0000, 8'h00, 1'b1, 1'b0, 1'b0);
    apply(32'h0000_0000, 32'hC040_0000);
    expect_all("R6 0/x", 32'h8000_0000, ONE, 32'h8000_0000, 8'h00, 1'b1, 1'b0, 1'b0);
    apply(32'hFF80_0000, 32'h4000_0000);
    expect_all("R6 inf/x", 32'hFF80_0000, ONE, 32'hFF80_0000, 8'h00, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_low_window;
    apply(32'h3F80_0000, 32'h7380_0000);
    expect_all("R7 D=23", 32'h5F80_0000, 32'h5380_0000, 32'd0, 8'hC0, 1'b0, 1'b0, 1'b0);
    apply(32'hBF80_0000, 32'h7380_0000);
    expect_all("R7 negative num", 32'hDF80_0000, 32'h5380_0000, 32'd0, 8'hC0, 1'b0, 1'b0, 1'b0);
    apply(32'h3F80_0000, 32'h7300_0000);
    expect_all("R9 D=24 unchanged", 32'h3F80_0000, 32'h7300_0000, 32'd0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_high_window;
    apply(32'h7380_0000, 32'h3F80_0000);
    expect_all("R8 D=231", 32'h6380_0000, 32'h4F80_0000, 32'd0, 8'h40, 1'b0, 1'b0, 1'b0);
    apply(32'h7300_0000, 32'h3F80_0000);
    expect_all("R9 D=230 unchanged", 32'h7300_0000, 32'h3F80_0000, 32'd0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_joint_windows;
    apply(32'h0C80_0000, 32'h0A00_0000);
    expect_all("R9 num exp 25", 32'h2C80_0000, 32'h2A00_0000, 32'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    apply(32'h0D00_0000, 32'h0A00_0000);
    expect_all("R9 num exp 26", 32'h0D00_0000, 32'h0A00_0000, 32'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    apply(32'h3200_0000, 32'h0080_0000);
    expect_all("R9 den exp 1", 32'h4200_0000, 32'h1080_0000, 32'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    apply(32'h6400_0000, 32'h7E80_0000);
    expect_all("R9 den exp 253", 32'h5400_0000, 32'h6E80_0000, 32'd0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_denormal;
    apply(32'h3200_0000, 32'h0040_0000);
    expect_all("R10 denormal den", 32'h4200_0000, 32'h1000_0000, 32'd0, 8'h00, 1'b0, 1'b0, 1'b0);
    apply(32'h0000_0001, 32'h3F80_0000);
    expect_all("R10 min denormal", 32'h1500_0000, 32'h1F80_0000, 32'd0, 8'hC0, 1'b0, 1'b0, 1'b0);
    apply(32'h8001_2345, 32'h3F80_0000);
    expect_all("R10 mantissa kept", 32'h9D11_A280, 32'h1F80_0000, 32'd0, 8'hC0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset_hold_pre: begin end
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    t_reset_hold();
    t_nan_pair();
    t_single_nan();
    t_collision();
    t_indeterminate();
    t_zero_den();
    t_zero_inf();
    t_low_window();
    t_high_window();
    t_joint_windows();
    t_denormal();
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule